// File: doc/BRIEF.md
# Power-Up Configuration Loader

This block owns the control register bank of a four-lane line redriver. When reset is applied, and again when it is released, it loads fixed defaults into the bank. It then keeps the device in a long startup blackout, counted in clock cycles, while `busy` stays high. During the blackout the serial-bus slave must stay silent. When the count expires the block takes one snapshot of the synchronized board strap pins and copies it into the matching field of every lane. After that it hands control to one of two owners.

The owner is chosen by the mode strap. In register mode (strap high) the straps have no further effect, and the lanes follow whatever the serial-bus slave writes into the bank. In pin mode (strap low) the live straps drive every lane in common. Bank writes are then accepted but dropped. A read returns the strap values in the lane-0 bits and zero in every other bit. The lane outputs cover the preemphasis code, the drive level, the output enable, the squelch indication, the detect-speed select and the offset-cancel enable.

The sequencer has three named states. `ST_WAIT` is entered by reset and counts the blackout; the `WAIT_DONE` transition leaves it once the count reaches `WAIT_CYCLES`-1. `ST_SNAP` lasts exactly one cycle and loads the snapshot; it always moves to `ST_RUN` through the `SNAP_DONE` transition. `ST_RUN` holds until the next reset.

Top module: `pwrup_cfg_loader`

## Requirements
- R1: While `rst` is high, `busy` is 1 and the bank holds defaults. The lane outputs are then `lane_pe`=8'h55, `lane_lvl`=8'hAA, `lane_oe`=4'hF, `lane_sds`=0 and `lane_ofc`=0, and `lane_sq` equals the inverse of `sig_det`.
- R2: After `rst` falls, `busy` stays 1 through the first `WAIT_CYCLES` rising edges. It is 0 after edge `WAIT_CYCLES`+1 and stays 0 until the next reset.
- R3: While `busy` is 1, bank writes are ignored and `rd_data` reads 0.
- R4: At the end of the wait, each synchronized strap value is written into its field for all four lanes.
- R5: In register mode, strap changes after the snapshot do not reach the lane outputs. Bank writes take effect on the lane outputs from the next clock edge.
- R6: In pin mode, the lane outputs follow the straps on every lane within `SYNC_STAGES`+1 edges. Bank writes change no register.
- R7: In pin mode, a read returns the strap value in the lane-0 bits of the addressed field and zero in all other bits.
- R8: Drive-level code 2'b11 is reserved and is driven out as 2'b10. Readback returns the raw stored code.
- R9: `lane_sq[c]` = `lane_oe[c]` & squelch-enable & !`sig_det[c]`. A lane that is powered down never shows squelch.
- R10: Addresses 6 and 7 read as 0, and writes to them change nothing.
- R11: The bank map has six addresses. Address 0 holds preemphasis and address 1 holds drive level, with lane c in bits [2c+1:2c]. Address 2 holds output enable, 3 squelch enable, 4 detect-speed select and 5 offset cancel, with lane c in bit c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset |
| strap_regmode | input | 1 | 1 = register mode, 0 = pin mode (asynchronous) |
| strap_en | input | 1 | Output enable strap |
| strap_lvl | input | 2 | Drive level strap |
| strap_pe | input | 2 | Preemphasis strap |
| strap_sq | input | 1 | Squelch enable strap |
| strap_sds | input | 1 | Fast/slow detect select strap |
| strap_ofc | input | 1 | Offset cancel strap |
| sig_det | input | 4 | Per-lane signal detect |
| wr_en | input | 1 | Bank write strobe from serial slave |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Startup blackout, gates the serial slave |
| lane_pe | output | 8 | Preemphasis code per lane |
| lane_lvl | output | 8 | Decoded drive level per lane |
| lane_oe | output | 4 | Output enable per lane |
| lane_sq | output | 4 | Squelch active per lane |
| lane_sds | output | 4 | Detect-speed select per lane |
| lane_ofc | output | 4 | Offset cancel per lane |

## Verification
The bench builds the block with `WAIT_CYCLES`=40, `SYNC_STAGES`=2 and four lanes. The short wait lets the exact edge at which `busy` falls be checked cycle by cycle, together with a write issued inside the blackout. The two-stage synchronizer bounds how long the bench waits before it checks strap-driven outputs in pin mode. Mode switches in both directions show that writes dropped in pin mode leave the bank intact, and that register mode ignores strap changes.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_SNAP = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_PE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LVL = 3'd1;
    localparam logic [ADDR_W-1:0] A_EN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SQ  = 3'd3;
    localparam logic [ADDR_W-1:0] A_SDS = 3'd4;
    localparam logic [ADDR_W-1:0] A_OFC = 3'd5;

    typedef struct packed {
        logic       ofc;
        logic       sds;
        logic       sq;
        logic       en;
        logic [1:0] lvl;
        logic [1:0] pe;
    } strap_t;

    localparam int unsigned STRAP_W = $bits(strap_t);

    localparam strap_t STRAP_DEFAULT = '{
        ofc: 1'b0, sds: 1'b0, sq: 1'b1, en: 1'b1, lvl: 2'b10, pe: 2'b01
    };

endpackage

// File: rtl/pcl_sync.sv
module pcl_sync #(
    parameter int unsigned      W       = 8,
    parameter int unsigned      STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= RST_VAL;
                    else     stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pcl_seq.sv
module pcl_seq
    import pcl_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic busy,
    output logic load
);
    localparam int unsigned CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

    seq_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic wait_done;

    assign wait_done = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                                cnt_q <= '0;
        else if (state_q == ST_WAIT && !wait_done) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (wait_done) state_d = ST_SNAP;
            ST_SNAP: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        busy = 1'b1;
        load = 1'b0;
        unique case (state_q)
            ST_WAIT: begin busy = 1'b1; load = 1'b0; end
            ST_SNAP: begin busy = 1'b1; load = 1'b1; end
            ST_RUN:  begin busy = 1'b0; load = 1'b0; end
            default: begin busy = 1'b1; load = 1'b0; end
        endcase
    end

    p_busy_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy);
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);
    p_load_once_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (!load && !busy));
endmodule

// File: rtl/pcl_regs.sv
module pcl_regs
    import pcl_pkg::*;
#(
    parameter int unsigned NCH = 4,
    localparam int unsigned DW = 2 * NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              load,
    input  logic              regmode,
    input  strap_t            straps,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     pe_q,
    output logic [DW-1:0]     lvl_q,
    output logic [NCH-1:0]    en_q,
    output logic [NCH-1:0]    sq_q,
    output logic [NCH-1:0]    sds_q,
    output logic [NCH-1:0]    ofc_q
);
    logic wr_ok;
    assign wr_ok = wr_en && !busy && regmode;

    always_ff @(posedge clk) begin
        if (rst) begin
            pe_q  <= {NCH{STRAP_DEFAULT.pe}};
            lvl_q <= {NCH{STRAP_DEFAULT.lvl}};
            en_q  <= {NCH{STRAP_DEFAULT.en}};
            sq_q  <= {NCH{STRAP_DEFAULT.sq}};
            sds_q <= {NCH{STRAP_DEFAULT.sds}};
            ofc_q <= {NCH{STRAP_DEFAULT.ofc}};
        end else if (load) begin
            pe_q  <= {NCH{straps.pe}};
            lvl_q <= {NCH{straps.lvl}};
            en_q  <= {NCH{straps.en}};
            sq_q  <= {NCH{straps.sq}};
            sds_q <= {NCH{straps.sds}};
            ofc_q <= {NCH{straps.ofc}};
        end else if (wr_ok) begin
            unique case (wr_addr)
                A_PE:    pe_q  <= wr_data;
                A_LVL:   lvl_q <= wr_data;
                A_EN:    en_q  <= wr_data[NCH-1:0];
                A_SQ:    sq_q  <= wr_data[NCH-1:0];
                A_SDS:   sds_q <= wr_data[NCH-1:0];
                A_OFC:   ofc_q <= wr_data[NCH-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (!busy) begin
            if (regmode) begin
                unique case (rd_addr)
                    A_PE:    rd_data = pe_q;
                    A_LVL:   rd_data = lvl_q;
                    A_EN:    rd_data = DW'(en_q);
                    A_SQ:    rd_data = DW'(sq_q);
                    A_SDS:   rd_data = DW'(sds_q);
                    A_OFC:   rd_data = DW'(ofc_q);
                    default: rd_data = '0;
                endcase
            end else begin
                unique case (rd_addr)
                    A_PE:    rd_data = DW'(straps.pe);
                    A_LVL:   rd_data = DW'(straps.lvl);
                    A_EN:    rd_data = DW'(straps.en);
                    A_SQ:    rd_data = DW'(straps.sq);
                    A_SDS:   rd_data = DW'(straps.sds);
                    A_OFC:   rd_data = DW'(straps.ofc);
                    default: rd_data = '0;
                endcase
            end
        end
    end

    p_busy_nowrite_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> ($stable(pe_q) && $stable(lvl_q) && $stable(en_q)
                             && $stable(sq_q) && $stable(sds_q) && $stable(ofc_q)));
    p_pin_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !regmode) |=> ($stable(pe_q) && $stable(lvl_q) && $stable(en_q)
                                 && $stable(sq_q) && $stable(sds_q) && $stable(ofc_q)));
    p_pin_readback_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !regmode && (rd_addr == A_PE || rd_addr == A_LVL))
            |-> (rd_data[DW-1:2] == '0));
    p_busy_read_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_data == '0));
endmodule

// File: rtl/pcl_lane.sv
module pcl_lane
    import pcl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       use_straps,
    input  strap_t     straps,
    input  logic [1:0] r_pe,
    input  logic [1:0] r_lvl,
    input  logic       r_en,
    input  logic       r_sq,
    input  logic       r_sds,
    input  logic       r_ofc,
    input  logic       sig_det,
    output logic [1:0] pe,
    output logic [1:0] lvl,
    output logic       oe,
    output logic       sq,
    output logic       sds,
    output logic       ofc
);
    logic [1:0] lvl_raw;
    logic       sq_en;

    always_comb begin
        if (use_straps) begin
            pe      = straps.pe;
            lvl_raw = straps.lvl;
            oe      = straps.en;
            sq_en   = straps.sq;
            sds     = straps.sds;
            ofc     = straps.ofc;
        end else begin
            pe      = r_pe;
            lvl_raw = r_lvl;
            oe      = r_en;
            sq_en   = r_sq;
            sds     = r_sds;
            ofc     = r_ofc;
        end
    end

    // reserved drive code folds onto the highest level
    assign lvl = (lvl_raw == 2'b11) ? 2'b10 : lvl_raw;
    // a powered-down lane never reports squelch
    assign sq  = oe && sq_en && !sig_det;

    p_pd_over_sq_r9: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !sq);
    p_lvl_legal_r8: assert property (@(posedge clk) disable iff (rst)
        lvl != 2'b11);
endmodule

// File: rtl/pwrup_cfg_loader.sv
module pwrup_cfg_loader
    import pcl_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 10_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_regmode,
    input  logic       strap_en,
    input  logic [1:0] strap_lvl,
    input  logic [1:0] strap_pe,
    input  logic       strap_sq,
    input  logic       strap_sds,
    input  logic       strap_ofc,
    input  logic [3:0] sig_det,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic [7:0] lane_pe,
    output logic [7:0] lane_lvl,
    output logic [3:0] lane_oe,
    output logic [3:0] lane_sq,
    output logic [3:0] lane_sds,
    output logic [3:0] lane_ofc
);
    localparam int unsigned NCH  = 4;
    localparam int unsigned SYNC_W = STRAP_W + 1;

    strap_t     straps_raw, straps_s;
    logic       regmode_s;
    logic       load;
    logic [SYNC_W-1:0] sync_q;

    logic [2*NCH-1:0] pe_q, lvl_q;
    logic [NCH-1:0]   en_q, sq_q, sds_q, ofc_q;

    assign straps_raw = '{ofc: strap_ofc, sds: strap_sds, sq: strap_sq,
                          en: strap_en, lvl: strap_lvl, pe: strap_pe};

    pcl_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b1, STRAP_DEFAULT})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({strap_regmode, straps_raw}),
        .q   (sync_q)
    );

    assign regmode_s = sync_q[SYNC_W-1];
    assign straps_s  = strap_t'(sync_q[STRAP_W-1:0]);

    pcl_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .load (load)
    );

    pcl_regs #(.NCH(NCH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .load    (load),
        .regmode (regmode_s),
        .straps  (straps_s),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pe_q    (pe_q),
        .lvl_q   (lvl_q),
        .en_q    (en_q),
        .sq_q    (sq_q),
        .sds_q   (sds_q),
        .ofc_q   (ofc_q)
    );

    logic use_straps;
    assign use_straps = !busy && !regmode_s;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_lane
            pcl_lane u_lane (
                .clk        (clk),
                .rst        (rst),
                .use_straps (use_straps),
                .straps     (straps_s),
                .r_pe       (pe_q[2*c +: 2]),
                .r_lvl      (lvl_q[2*c +: 2]),
                .r_en       (en_q[c]),
                .r_sq       (sq_q[c]),
                .r_sds      (sds_q[c]),
                .r_ofc      (ofc_q[c]),
                .sig_det    (sig_det[c]),
                .pe         (lane_pe[2*c +: 2]),
                .lvl        (lane_lvl[2*c +: 2]),
                .oe         (lane_oe[c]),
                .sq         (lane_sq[c]),
                .sds        (lane_sds[c]),
                .ofc        (lane_ofc[c])
            );
        end
    endgenerate

    p_pin_uniform_r6: assert property (@(posedge clk) disable iff (rst)
        use_straps |-> (lane_pe == {NCH{lane_pe[1:0]}} && lane_oe == {NCH{lane_oe[0]}}));
endmodule

// File: tb/pwrup_cfg_loader_tb.sv
module pwrup_cfg_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_N     = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_regmode = 1'b1;
    logic       strap_en = 1'b1;
    logic [1:0] strap_lvl = 2'b01;
    logic [1:0] strap_pe = 2'b11;
    logic       strap_sq = 1'b0;
    logic       strap_sds = 1'b1;
    logic       strap_ofc = 1'b1;
    logic [3:0] sig_det = 4'h0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;
    logic [7:0] lane_pe, lane_lvl;
    logic [3:0] lane_oe, lane_sq, lane_sds, lane_ofc;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrup_cfg_loader #(.WAIT_CYCLES(WAIT_N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .strap_regmode(strap_regmode), .strap_en(strap_en),
        .strap_lvl(strap_lvl), .strap_pe(strap_pe), .strap_sq(strap_sq),
        .strap_sds(strap_sds), .strap_ofc(strap_ofc), .sig_det(sig_det),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .lane_pe(lane_pe), .lane_lvl(lane_lvl),
        .lane_oe(lane_oe), .lane_sq(lane_sq), .lane_sds(lane_sds), .lane_ofc(lane_ofc)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "busy", {7'd0, busy}, 8'h01);
        chk("R1", "pe", lane_pe, 8'h55);
        chk("R1", "lvl", lane_lvl, 8'hAA);
        chk("R1", "oe", {4'd0, lane_oe}, 8'h0F);
        chk("R1", "sq", {4'd0, lane_sq}, 8'h0F);
        chk("R1", "sds", {4'd0, lane_sds}, 8'h00);
        chk("R1", "ofc", {4'd0, lane_ofc}, 8'h00);
        bus_read(3'd0, v);
        chk("R3", "read in reset", v, 8'h00);
    endtask

    task automatic t_wait_and_snap();
        logic [7:0] v;
        @(negedge clk);
        rst = 1'b0;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h00;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R3", "write in blackout", lane_pe, 8'h55);
        chk("R3", "read in blackout", rd_data, 8'h00);
        repeat (WAIT_N - 1) @(posedge clk);
        #1 chk("R2", "busy at last wait edge", {7'd0, busy}, 8'h01);
        @(posedge clk);
        #1 chk("R2", "busy after snap", {7'd0, busy}, 8'h00);
        chk("R4", "pe", lane_pe, 8'hFF);
        chk("R4", "lvl", lane_lvl, 8'h55);
        chk("R4", "oe", {4'd0, lane_oe}, 8'h0F);
        chk("R4", "sq", {4'd0, lane_sq}, 8'h00);
        chk("R4", "sds", {4'd0, lane_sds}, 8'h0F);
        chk("R4", "ofc", {4'd0, lane_ofc}, 8'h0F);
        bus_read(3'd0, v); chk("R4", "rd pe", v, 8'hFF);
        bus_read(3'd1, v); chk("R4", "rd lvl", v, 8'h55);
        bus_read(3'd4, v); chk("R11", "rd sds", v, 8'h0F);
        repeat (3) @(posedge clk);
        #1 chk("R2", "busy stays low", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_regmode();
        @(negedge clk);
        strap_pe = 2'b00; strap_en = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R5", "pe ignores strap", lane_pe, 8'hFF);
        chk("R5", "oe ignores strap", {4'd0, lane_oe}, 8'h0F);
        bus_write(3'd0, 8'h1B);
        chk("R5", "pe after write", lane_pe, 8'h1B);
    endtask

    task automatic t_lvl_reserved();
        logic [7:0] v;
        bus_write(3'd1, 8'hE4);
        chk("R8", "lvl decode", lane_lvl, 8'hA4);
        bus_read(3'd1, v);
        chk("R8", "lvl raw readback", v, 8'hE4);
    endtask

    task automatic t_squelch();
        @(negedge clk) sig_det = 4'b0011;
        bus_write(3'd2, 8'h05);
        bus_write(3'd3, 8'h0F);
        chk("R9", "oe", {4'd0, lane_oe}, 8'h05);
        chk("R9", "sq", {4'd0, lane_sq}, 8'h04);
        @(negedge clk) sig_det = 4'b0000;
        #1 chk("R9", "sq no detect", {4'd0, lane_sq}, 8'h05);
    endtask

    task automatic t_addr_range();
        logic [7:0] v;
        bus_write(3'd6, 8'hFF);
        bus_write(3'd7, 8'hFF);
        bus_read(3'd6, v); chk("R10", "rd 6", v, 8'h00);
        bus_read(3'd7, v); chk("R10", "rd 7", v, 8'h00);
        bus_read(3'd0, v); chk("R10", "rd 0 intact", v, 8'h1B);
        bus_read(3'd2, v); chk("R10", "rd 2 intact", v, 8'h05);
        bus_read(3'd5, v); chk("R10", "rd 5 intact", v, 8'h0F);
    endtask

    task automatic t_pinmode();
        logic [7:0] v;
        @(negedge clk);
        strap_regmode = 1'b0; strap_pe = 2'b10; strap_lvl = 2'b11; strap_en = 1'b1;
        strap_sq = 1'b1; strap_sds = 1'b0; strap_ofc = 1'b1; sig_det = 4'h0;
        repeat (4) @(posedge clk);
        #1;
        chk("R6", "pe", lane_pe, 8'hAA);
        chk("R8", "lvl strap 11", lane_lvl, 8'hAA);
        chk("R6", "oe", {4'd0, lane_oe}, 8'h0F);
        chk("R6", "sq", {4'd0, lane_sq}, 8'h0F);
        chk("R6", "sds", {4'd0, lane_sds}, 8'h00);
        chk("R6", "ofc", {4'd0, lane_ofc}, 8'h0F);
        bus_read(3'd0, v); chk("R7", "rd pe", v, 8'h02);
        bus_read(3'd1, v); chk("R7", "rd lvl", v, 8'h03);
        bus_read(3'd2, v); chk("R7", "rd en", v, 8'h01);
        bus_read(3'd4, v); chk("R7", "rd sds", v, 8'h00);
        bus_write(3'd0, 8'h00);
        @(negedge clk) strap_en = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R9", "pin powerdown oe", {4'd0, lane_oe}, 8'h00);
        chk("R9", "pin powerdown sq", {4'd0, lane_sq}, 8'h00);
        @(negedge clk) strap_regmode = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk("R6", "write dropped, pe", lane_pe, 8'h1B);
        bus_read(3'd0, v); chk("R6", "write dropped, rd", v, 8'h1B);
    endtask

    initial begin
        t_reset();
        t_wait_and_snap();
        t_regmode();
        t_lvl_reserved();
        t_squelch();
        t_addr_range();
        t_pinmode();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule